// File: doc/BRIEF.md
# Dual 8-bit Compare Timer with Capture Mode

This block holds two 8-bit timer channels that share one count enable. Each channel has a free-running counter and two compare registers. A compare match sets a sticky flag, can raise an interrupt, and on the A side can toggle the channel's output pin. Software reaches every register through a small synchronous write bus. Reads are combinational from the address.

A single mode bit, held in the second channel's control register, reconfigures the pair. With the bit set, channel 1's B register stops comparing. Instead it latches the channel 1 count on each synchronized rising edge of the capture pin, and that capture sets flag B. At the same time, channel 0's B comparison is muted: it sets no flag, changes no pin and raises no interrupt. Both A comparisons work the same in either mode.

Register map: address bit 2 selects the channel, and bits 1:0 select the register (0 = counter, 1 = compare A, 2 = compare B, 3 = control).

Control register bits:

| Bit | Meaning |
|-----|---------|
| 0 | Flag A |
| 1 | Flag B |
| 2 | Interrupt enable A |
| 3 | Interrupt enable B |
| 4 | Output toggle enable |
| 5 | Capture mode (channel 1 only; reads 0 on channel 0) |
| 7:6 | Read 0 |

Top module: `tmr_pair_cap`

## Requirements
- R1: On every cycle with `cnt_en` high, each counter advances by one and wraps from 0xFF to 0x00. A bus write to the counter (register 0) loads it instead, and the write takes priority over counting.
- R2: When a counter equals its compare A value on a counting cycle, that channel's flag A (control bit 0) is set on the next clock. This holds in both modes.
- R3: Flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. If a set and a clearing write land in the same cycle, the set wins.
- R4: `irq_a[n]` is high exactly when channel n's flag A and enable A (bit 2) are both set. `irq_b[n]` is high exactly when flag B and enable B (bit 3) are both set.
- R5: `tmo[n]` toggles on a channel n compare A match when the output enable (bit 4) is set. It holds its level otherwise, and B matches never change it.
- R6: With capture mode clear, a compare B match on a counting cycle sets flag B on both channels.
- R7: With capture mode set, a channel 0 compare B match sets no flag B, raises no `irq_b[0]` and leaves `tmo[0]` alone. The channel 0 compare A path keeps working.
- R8: With capture mode set, a rising edge on `cap_pin` copies channel 1's counter into its B register and sets its flag B on the third clock edge after the pin rises (two synchronizer flops plus the edge register). A channel 1 compare B match does nothing in this mode.
- R9: With capture mode clear, `cap_pin` has no effect on any register or output.
- R10: After reset, all registers read 0 and all pins and interrupts are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| cnt_en | input | 1 | Prescaled count enable |
| cap_pin | input | 1 | Capture input (channel 1 timer I/O) |
| tmo | output | 2 | Timer output pins, one per channel |
| irq_a | output | 2 | Compare A interrupts |
| irq_b | output | 2 | Compare B / capture interrupts |

## Verification
Most internal faults show up at the pins one clock after the cycle that causes them, because interrupts and timer outputs come straight from registered flags:
- A counter that drifts moves the next match. The wrong edge then appears on `irq_a`/`tmo` within one counter period.
- A mode decode that leaks makes `irq_b[0]` rise while capture mode is set, or leaves `irq_b[1]` low three edges after a pin rise.
- A broken capture path shows up in the captured value on the next read of channel 1's B register.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;
  localparam int CNT_W  = 8;
  localparam int NCH    = 2;
  localparam int RSEL_W = 2;
  localparam int CH_W   = $clog2(NCH);
  localparam int ADDR_W = CH_W + RSEL_W;

  typedef enum logic [RSEL_W-1:0] {
    RSEL_CNT  = 2'd0,
    RSEL_CMPA = 2'd1,
    RSEL_CMPB = 2'd2,
    RSEL_CTL  = 2'd3
  } rsel_e;

  localparam int CTL_FA  = 0;
  localparam int CTL_FB  = 1;
  localparam int CTL_IEA = 2;
  localparam int CTL_IEB = 3;
  localparam int CTL_OE  = 4;
  localparam int CTL_CAP = 5;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= {hold_q[0], 1'b1};
  end

  assign rst_sync_n = hold_q[1];
endmodule

// File: rtl/tmr_cap_sync.sv
module tmr_cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // last synchronized sample high, edge register still low
  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pair_pkg::*;
#(
  parameter int W      = CNT_W,
  parameter bit IS_CAP = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         wr_cnt,
  input  logic         wr_cmpa,
  input  logic         wr_cmpb,
  input  logic         wr_ctl,
  input  logic [W-1:0] wdata,
  input  logic         cap_mode,
  input  logic         cap_evt,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cmpa_o,
  output logic [W-1:0] cmpb_o,
  output logic [W-1:0] ctl_o,
  output logic         tmo_o,
  output logic         irq_a_o,
  output logic         irq_b_o
);
  logic [W-1:0] cnt_q, cnt_d, cmpa_q, cmpa_d, cmpb_q, cmpb_d;
  logic fa_q, fa_d, fb_q, fb_d;
  logic iea_q, iea_d, ieb_q, ieb_d, oe_q, oe_d, tmo_q, tmo_d;
  logic match_a, match_b, set_a, set_b, silence_b, capture_b, cap_load;
  logic clr_a, clr_b;
  logic unused_bits;

  assign unused_bits = ^wdata[W-1:CTL_CAP];

  // mode split: this channel either mutes its B compare or turns B into capture
  assign silence_b = cap_mode & ~IS_CAP;
  assign capture_b = cap_mode & IS_CAP;

  assign match_a  = cnt_en & (cnt_q == cmpa_q);
  assign match_b  = cnt_en & (cnt_q == cmpb_q);
  assign cap_load = capture_b & cap_evt;
  assign set_a    = match_a;
  assign set_b    = capture_b ? cap_evt : (match_b & ~silence_b);
  assign clr_a    = wr_ctl & ~wdata[CTL_FA];
  assign clr_b    = wr_ctl & ~wdata[CTL_FB];

  always_comb begin
    cnt_d  = cnt_q;
    if (wr_cnt)      cnt_d = wdata;
    else if (cnt_en) cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
    cmpa_d = wr_cmpa ? wdata : cmpa_q;
    cmpb_d = cmpb_q;
    if (cap_load)     cmpb_d = cnt_q;
    else if (wr_cmpb) cmpb_d = wdata;
    fa_d   = (fa_q & ~clr_a) | set_a;
    fb_d   = (fb_q & ~clr_b) | set_b;
    iea_d  = wr_ctl ? wdata[CTL_IEA] : iea_q;
    ieb_d  = wr_ctl ? wdata[CTL_IEB] : ieb_q;
    oe_d   = wr_ctl ? wdata[CTL_OE]  : oe_q;
    tmo_d  = tmo_q ^ (match_a & oe_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      fa_q   <= 1'b0;
      fb_q   <= 1'b0;
      iea_q  <= 1'b0;
      ieb_q  <= 1'b0;
      oe_q   <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cmpa_q <= cmpa_d;
      cmpb_q <= cmpb_d;
      fa_q   <= fa_d;
      fb_q   <= fb_d;
      iea_q  <= iea_d;
      ieb_q  <= ieb_d;
      oe_q   <= oe_d;
      tmo_q  <= tmo_d;
    end
  end

  always_comb begin
    ctl_o          = '0;
    ctl_o[CTL_FA]  = fa_q;
    ctl_o[CTL_FB]  = fb_q;
    ctl_o[CTL_IEA] = iea_q;
    ctl_o[CTL_IEB] = ieb_q;
    ctl_o[CTL_OE]  = oe_q;
    ctl_o[CTL_CAP] = capture_b;
  end

  assign cnt_o   = cnt_q;
  assign cmpa_o  = cmpa_q;
  assign cmpb_o  = cmpb_q;
  assign tmo_o   = tmo_q;
  assign irq_a_o = fa_q & iea_q;
  assign irq_b_o = fb_q & ieb_q;

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !wr_cnt && (cnt_q == {W{1'b1}})) |=> (cnt_q == '0)); // R1
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fa_q && !(wr_ctl && !wdata[CTL_FA])) |=> fa_q); // R3
  AST_TMO_FROM_A: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tmo_q) |-> $past(match_a && oe_q)); // R5
  AST_B_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_mode && match_b) |=> fb_q); // R6
  AST_B_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    silence_b |=> !$rose(fb_q)); // R7
  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_b && cap_evt) |=> ((cmpb_q == $past(cnt_q)) && fb_q)); // R8
  AST_CAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_b && !wr_cmpb) |=> $stable(cmpb_q)); // R9
endmodule

// File: rtl/tmr_pair_cap.sv
module tmr_pair_cap
  import tmr_pair_pkg::*;
#(
  parameter int W           = CNT_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic              cnt_en,
  input  logic              cap_pin,
  output logic [NCH-1:0]    tmo,
  output logic [NCH-1:0]    irq_a,
  output logic [NCH-1:0]    irq_b
);
  logic            rst_core_n;
  logic            cap_rise;
  logic            cap_mode_q, cap_mode_d;
  logic [CH_W-1:0] ch_sel;
  rsel_e           rsel;
  logic [NCH-1:0]  wr_cnt_v, wr_cmpa_v, wr_cmpb_v, wr_ctl_v;
  logic [W-1:0]    cnt_a  [NCH];
  logic [W-1:0]    cmpa_a [NCH];
  logic [W-1:0]    cmpb_a [NCH];
  logic [W-1:0]    ctl_a  [NCH];

  tmr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  tmr_cap_sync #(.STAGES(SYNC_STAGES)) u_cap (
    .clk   (clk),
    .rst_n (rst_core_n),
    .pin   (cap_pin),
    .rise  (cap_rise)
  );

  assign ch_sel = bus_addr[ADDR_W-1:RSEL_W];
  assign rsel   = rsel_e'(bus_addr[RSEL_W-1:0]);

  // the mode bit sits in the last channel's control register
  always_comb cap_mode_d = wr_ctl_v[NCH-1] ? bus_wdata[CTL_CAP] : cap_mode_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) cap_mode_q <= 1'b0;
    else             cap_mode_q <= cap_mode_d;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit          = bus_wr && (ch_sel == CH_W'(g));
    assign wr_cnt_v[g]  = hit && (rsel == RSEL_CNT);
    assign wr_cmpa_v[g] = hit && (rsel == RSEL_CMPA);
    assign wr_cmpb_v[g] = hit && (rsel == RSEL_CMPB);
    assign wr_ctl_v[g]  = hit && (rsel == RSEL_CTL);

    tmr_chan #(.W(W), .IS_CAP(g == NCH-1)) u_chan (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .cnt_en   (cnt_en),
      .wr_cnt   (wr_cnt_v[g]),
      .wr_cmpa  (wr_cmpa_v[g]),
      .wr_cmpb  (wr_cmpb_v[g]),
      .wr_ctl   (wr_ctl_v[g]),
      .wdata    (bus_wdata),
      .cap_mode (cap_mode_q),
      .cap_evt  (cap_rise),
      .cnt_o    (cnt_a[g]),
      .cmpa_o   (cmpa_a[g]),
      .cmpb_o   (cmpb_a[g]),
      .ctl_o    (ctl_a[g]),
      .tmo_o    (tmo[g]),
      .irq_a_o  (irq_a[g]),
      .irq_b_o  (irq_b[g])
    );
  end

  always_comb begin
    case (rsel)
      RSEL_CNT:  bus_rdata = cnt_a[ch_sel];
      RSEL_CMPA: bus_rdata = cmpa_a[ch_sel];
      RSEL_CMPB: bus_rdata = cmpb_a[ch_sel];
      default:   bus_rdata = ctl_a[ch_sel];
    endcase
  end

  AST_CH0_B_QUIET: assert property (@(posedge clk) disable iff (!rst_core_n)
    cap_mode_q |=> !$rose(irq_b[0])); // R7
endmodule

// File: tb/tmr_pair_cap_tb.sv
`timescale 1ns/1ps
module tmr_pair_cap_tb_top;
  logic       clk;
  logic       rst_n;
  logic       bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       cnt_en;
  logic       cap_pin;
  logic [1:0] tmo, irq_a, irq_b;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] m_cnt[2], m_ca[2], m_cb[2];
  logic m_fa[2], m_fb[2], m_iea[2], m_ieb[2], m_oe[2], m_tmo[2];
  logic m_cap;
  logic [1:0] m_pipe;
  logic pin_prev;

  tmr_pair_cap dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_en(cnt_en),
    .cap_pin(cap_pin), .tmo(tmo), .irq_a(irq_a), .irq_b(irq_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_reg(input logic [2:0] a);
    int ch;
    ch = int'(a[2]);
    case (a[1:0])
      2'd0: return m_cnt[ch];
      2'd1: return m_ca[ch];
      2'd2: return m_cb[ch];
      default: return {2'b00, (ch == 1) ? m_cap : 1'b0, m_oe[ch],
                       m_ieb[ch], m_iea[ch], m_fb[ch], m_fa[ch]};
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a[1:0])
      2'd0: return "R1";
      2'd1: return "R10";
      2'd2: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic model_update(input logic en, input logic wr, input logic [2:0] a,
                              input logic [7:0] d, input logic rise);
    logic cap_now;
    cap_now = m_pipe[1];
    m_pipe  = {m_pipe[0], rise};
    for (int ch = 0; ch < 2; ch++) begin
      logic ma, mb, sb, w, capld, tog;
      logic [7:0] oc;
      oc    = m_cnt[ch];
      ma    = en && (m_cnt[ch] == m_ca[ch]);
      mb    = en && (m_cnt[ch] == m_cb[ch]);
      sb    = (ch == 1 && m_cap) ? cap_now : (mb && !m_cap);
      capld = (ch == 1) && m_cap && cap_now;
      tog   = ma && m_oe[ch];
      w     = wr && (int'(a[2]) == ch);
      if (w && a[1:0] == 2'd0) m_cnt[ch] = d;
      else if (en)             m_cnt[ch] = m_cnt[ch] + 8'd1;
      if (w && a[1:0] == 2'd1) m_ca[ch] = d;
      if (capld)                    m_cb[ch] = oc;
      else if (w && a[1:0] == 2'd2) m_cb[ch] = d;
      if (w && a[1:0] == 2'd3) begin
        if (!d[0]) m_fa[ch] = 1'b0;
        if (!d[1]) m_fb[ch] = 1'b0;
        m_iea[ch] = d[2];
        m_ieb[ch] = d[3];
        m_oe[ch]  = d[4];
      end
      if (ma) m_fa[ch] = 1'b1;
      if (sb) m_fb[ch] = 1'b1;
      m_tmo[ch] = m_tmo[ch] ^ tog;
    end
    if (wr && a == 3'd7) m_cap = d[5];
  endtask

  task automatic step(input logic en, input logic wr, input logic [2:0] a, input logic [7:0] d);
    logic rise;
    @(negedge clk);
    cnt_en = en; bus_wr = wr; bus_addr = a; bus_wdata = d;
    rise = cap_pin && !pin_prev;
    pin_prev = cap_pin;
    @(posedge clk);
    model_update(en, wr, a, d, rise);
    #5;
    for (int ch = 0; ch < 2; ch++) begin
      chk("R4", irq_a[ch], m_fa[ch] & m_iea[ch]);
      chk("R4", irq_b[ch], m_fb[ch] & m_ieb[ch]);
      chk("R5", tmo[ch], m_tmo[ch]);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    step(1'b0, 1'b1, a, d);
  endtask

  task automatic rd_chk(input logic [2:0] a, input string req, input logic [7:0] exp);
    bus_wr = 1'b0;
    bus_addr = a;
    #0.1;
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_7a11));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    cnt_en = 1'b0; cap_pin = 1'b0; pin_prev = 1'b0;
    m_cap = 1'b0; m_pipe = '0;
    for (int ch = 0; ch < 2; ch++) begin
      m_cnt[ch] = '0; m_ca[ch] = '0; m_cb[ch] = '0;
      m_fa[ch] = 0; m_fb[ch] = 0; m_iea[ch] = 0; m_ieb[ch] = 0; m_oe[ch] = 0; m_tmo[ch] = 0;
    end
    repeat (3) @(posedge clk);
    #5;
    for (int a = 0; a < 8; a++) rd_chk(3'(a), "R10", 8'h00);
    chk("R10", {tmo, irq_a, irq_b}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b0, 3'd0, 8'h00);

    // R1: wrap
    wr_reg(3'd0, 8'hFE);
    step(1'b1, 1'b0, 3'd0, 8'h00);
    step(1'b1, 1'b0, 3'd0, 8'h00);
    rd_chk(3'd0, "R1", 8'h00);

    // R2 R4 R5: channel 0 A match
    wr_reg(3'd1, 8'h10);
    wr_reg(3'd3, 8'h14);
    wr_reg(3'd0, 8'h0E);
    step(1'b1, 1'b0, 3'd0, 8'h00);
    step(1'b1, 1'b0, 3'd0, 8'h00);
    chk("R2", irq_a[0], 0);
    step(1'b1, 1'b0, 3'd0, 8'h00);
    chk("R2", irq_a[0], 1);
    chk("R5", tmo[0], 1);
    rd_chk(3'd3, "R2", 8'h15);

    // R3: write 1 keeps, write 0 clears, set beats clear
    wr_reg(3'd3, 8'h15);
    rd_chk(3'd3, "R3", 8'h15);
    wr_reg(3'd3, 8'h14);
    rd_chk(3'd3, "R3", 8'h14);
    chk("R4", irq_a[0], 0);
    wr_reg(3'd0, 8'h10);
    step(1'b1, 1'b1, 3'd3, 8'h14);
    rd_chk(3'd3, "R3", 8'h15);
    chk("R5", tmo[0], 0);

    // R6: B compares in normal mode
    wr_reg(3'd6, 8'h30);
    wr_reg(3'd4, 8'h30);
    wr_reg(3'd7, 8'h08);
    step(1'b1, 1'b0, 3'd0, 8'h00);
    chk("R6", irq_b[1], 1);
    wr_reg(3'd2, 8'h20);
    wr_reg(3'd0, 8'h20);
    wr_reg(3'd3, 8'h0C);
    step(1'b1, 1'b0, 3'd0, 8'h00);
    chk("R6", irq_b[0], 1);

    // R7: capture mode mutes channel 0 B
    wr_reg(3'd7, 8'h28);
    wr_reg(3'd3, 8'h1C);
    wr_reg(3'd0, 8'h20);
    step(1'b1, 1'b0, 3'd0, 8'h00);
    chk("R7", irq_b[0], 0);
    chk("R7", tmo[0], 0);
    rd_chk(3'd3, "R7", 8'h1C);
    wr_reg(3'd0, 8'h10);
    step(1'b1, 1'b0, 3'd0, 8'h00);
    chk("R7", irq_a[0], 1);
    chk("R7", tmo[0], 1);

    // R8: capture on synchronized rising edge
    wr_reg(3'd4, 8'h5A);
    cap_pin = 1'b1;
    step(1'b0, 1'b0, 3'd0, 8'h00);
    step(1'b0, 1'b0, 3'd0, 8'h00);
    rd_chk(3'd6, "R8", 8'h30);
    chk("R8", irq_b[1], 0);
    step(1'b0, 1'b0, 3'd0, 8'h00);
    rd_chk(3'd6, "R8", 8'h5A);
    chk("R8", irq_b[1], 1);
    cap_pin = 1'b0;
    wr_reg(3'd7, 8'h28);
    wr_reg(3'd4, 8'h5A);
    step(1'b1, 1'b0, 3'd0, 8'h00);
    chk("R8", irq_b[1], 0);

    // R9: pin ignored in normal mode
    wr_reg(3'd7, 8'h08);
    step(1'b0, 1'b0, 3'd0, 8'h00);
    cap_pin = 1'b1;
    repeat (4) step(1'b0, 1'b0, 3'd0, 8'h00);
    rd_chk(3'd6, "R9", 8'h5A);
    chk("R9", irq_b[1], 0);
    cap_pin = 1'b0;
    step(1'b0, 1'b0, 3'd0, 8'h00);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic wr;
      logic [2:0] a;
      logic [7:0] d;
      wr = ($urandom % 4) == 0;
      a  = 3'($urandom);
      d  = 8'($urandom);
      if (a[1:0] == 2'd0 && ($urandom % 2) == 0) d = 8'hFC | d[1:0];
      if (($urandom % 5) == 0) cap_pin = ~cap_pin;
      step(($urandom % 10) < 7, wr, a, d);
      if ((i % 16) == 15)
        for (int r = 0; r < 8; r++) rd_chk(3'(r), tag_of(3'(r)), exp_reg(3'(r)));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule